// File: doc/BRIEF.md
# Scanline Detector and Line Interrupt Counter

This block lives inside a cartridge-side memory mapper and has no direct view of video timing. It works out where each rendered scanline begins by watching the video processor's read bus. At the end of every line the video processor fetches the same nametable byte several times in a row. The block treats the third identical consecutive read inside the nametable window as the start of a new line. An "in-frame" flag follows whether rendering is active. The flag is armed by the first line start, confirmed by the next true nametable fetch, and dropped when the bus goes quiet for a few CPU clocks or when the CPU fetches an interrupt vector.

Each line start after the first advances an 8-bit line count. When the count equals a target that the CPU has programmed, an interrupt-pending flag is set. The interrupt output is that flag gated by an enable bit. A per-line tile-fetch index counts true nametable fetches and returns to zero at every line start, so neighbouring logic can tell which tile column is being fetched. The CPU controls the block through a register write port with two targets (line target and enable), a status read strobe, and its normal read address, which the block decodes for the vector fetch.

Top module: `scanline_irq_unit`

## Requirements
- R1: After reset the in-frame flag, line count, interrupt-pending flag, interrupt line, tile index and status byte are all zero.
- R2: Only video reads in 0x2000..0x2FFF take part in detection. A read in that window at the same address as the previous video read raises a repeat count, which saturates at 3. Any other video read sets the repeat count to 0. A line start happens only on the read that takes the repeat count from 1 to 2, so a fourth identical read is not a line start.
- R3: A line start seen while both the in-frame flag and the internal armed flag are clear sets the armed flag and loads the line count with 0. The next true nametable fetch then clears the armed flag and sets in-frame. A true nametable fetch is a read in the window whose low 10 address bits are below 0x3C0.
- R4: A line start seen while in-frame or armed is set increments the 8-bit line count, wrapping from 255 to 0.
- R5: When an increment makes the line count equal the programmed target, the interrupt-pending flag is set. The interrupt line is high exactly while pending and enable are both set, one cycle after either changes.
- R6: A true nametable fetch increments the tile index. A line start sets it to 0, and that reset wins over the fetch's own increment. Attribute reads (low 10 bits at or above 0x3C0) leave it unchanged.
- R7: Every video read reloads an idle counter with 3. Each CPU clock enable in a cycle without a video read decrements the idle counter while it is nonzero. The decrement that reaches 0 clears in-frame.
- R8: A CPU read at 0xFFFA or 0xFFFB clears in-frame, the line count, the interrupt-pending flag and the stored previous video address. CPU reads at other addresses have no effect.
- R9: The status byte carries interrupt-pending in bit 7 and in-frame in bit 6, with zeros elsewhere. A status read strobe clears interrupt-pending.
- R10: A register write with select 0 loads the line target from the data byte. A write with select 1 loads the enable from data bit 7 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_rd | input | 1 | Video read strobe, one cycle per read |
| vid_addr | input | 14 | Video read address |
| cpu_ce | input | 1 | One-cycle CPU clock enable |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | 16 | CPU read address (decoded for vector fetches) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 line target, 1 enable |
| reg_wdata | input | 8 | Register write data |
| status_rd | input | 1 | Status read strobe; clears interrupt-pending |
| in_frame | output | 1 | Rendering-active flag |
| line_count | output | 8 | Current line count |
| irq_pending | output | 1 | Interrupt-pending flag |
| irq | output | 1 | Interrupt request line |
| tile_idx | output | 6 | Per-line tile-fetch index |
| status | output | 8 | Status byte |

## Verification
The bench checks the repeat rule from both sides. A read outside the window between two identical reads must break the sequence, and a fourth identical read must not count a second line; a design that compared against the wrong previous address or fired on every repeat past two would count extra lines. It checks that the line-start reset of the tile index wins over the same read's increment. It checks that a vector fetch clears the stored previous address, and a design that missed this would turn a later read into a false line start and zero the tile index. It also drives 256 lines to reach a target of 0 through wrap-around, enables the interrupt while a request is already pending, and lets the idle timeout expire before re-arming, where a design that kept a stale count would resume from the old value.

// File: rtl/scanline_pkg.sv
package scanline_pkg;

    typedef enum logic {
        SEL_TARGET = 1'b0,
        SEL_ENABLE = 1'b1
    } sl_reg_e;

    localparam logic [15:0] NT_WIN_LO   = 16'h2000;
    localparam logic [15:0] NT_WIN_HI   = 16'h2FFF;
    localparam logic [9:0]  ATTR_OFFSET = 10'h3C0;
    localparam logic [15:0] VEC_LO_ADDR = 16'hFFFA;
    localparam logic [15:0] VEC_HI_ADDR = 16'hFFFB;

endpackage

// File: rtl/sl_fetch_watch.sv
module sl_fetch_watch
    import scanline_pkg::*;
#(
    parameter int VA_W   = 14,
    parameter int TILE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_rd_i,
    input  logic [VA_W-1:0]   vid_addr_i,
    input  logic              vec_rd_i,
    output logic              start_o,
    output logic              nt_fetch_o,
    output logic [TILE_W-1:0] tile_o
);
    localparam logic [VA_W-1:0] WIN_LO = VA_W'(NT_WIN_LO);
    localparam logic [VA_W-1:0] WIN_HI = VA_W'(NT_WIN_HI);
    localparam logic [1:0]      REP_MAX = 2'd3;
    localparam logic [1:0]      REP_FIRE_FROM = 2'd1;

    typedef struct packed {
        logic [VA_W-1:0]   last;
        logic [1:0]        rep;
        logic [TILE_W-1:0] tile;
    } fw_state_t;

    fw_state_t s_d, s_q;
    logic in_win, is_attr, same_addr;
    logic start_d, nt_d;

    always_comb begin
        in_win    = (vid_addr_i >= WIN_LO) && (vid_addr_i <= WIN_HI);
        is_attr   = (vid_addr_i[9:0] >= ATTR_OFFSET);
        same_addr = (vid_addr_i == s_q.last);
        nt_d      = vid_rd_i && in_win && !is_attr;
        start_d   = 1'b0;
        s_d       = s_q;
        if (vid_rd_i) begin
            if (in_win && same_addr) begin
                s_d.rep = (s_q.rep == REP_MAX) ? REP_MAX : s_q.rep + 2'd1;
                start_d = (s_q.rep == REP_FIRE_FROM);
            end else begin
                s_d.rep = 2'd0;
            end
            s_d.last = vid_addr_i;
            if (nt_d) begin
                s_d.tile = s_q.tile + TILE_W'(1);
            end
            if (start_d) begin
                s_d.tile = '0;
            end
        end
        if (vec_rd_i) begin
            s_d.last = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign start_o    = start_d;
    assign nt_fetch_o = nt_d;
    assign tile_o     = s_q.tile;

    // R2: a line start needs at least two further reads before the next one
    a_r2_start_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R2: a line start is always a read inside the nametable window
    a_r2_start_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (vid_rd_i && vid_addr_i >= WIN_LO && vid_addr_i <= WIN_HI));

    // R6: tile index is zero right after a line start
    a_r6_tile_zero: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (tile_o == '0));

endmodule

// File: rtl/sl_idle_timer.sv
module sl_idle_timer #(
    parameter int IDLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vid_rd_i,
    input  logic cpu_ce_i,
    output logic timeout_o
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(IDLE_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } it_state_t;

    it_state_t s_d, s_q;
    logic to_d;

    always_comb begin
        s_d  = s_q;
        to_d = 1'b0;
        if (vid_rd_i) begin
            s_d.cnt = RELOAD;
        end else if (cpu_ce_i && s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CW'(1);
            to_d    = (s_q.cnt == CW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign timeout_o = to_d;

    // R7: the timeout never coincides with bus activity
    a_r7_quiet_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!vid_rd_i && cpu_ce_i));

endmodule

// File: rtl/sl_line_state.sv
module sl_line_state
    import scanline_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              nt_fetch_i,
    input  logic              timeout_i,
    input  logic              vec_rd_i,
    input  logic              status_rd_i,
    input  logic              reg_wr_i,
    input  logic              reg_sel_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic              in_frame_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              pending_o,
    output logic              irq_o
);
    localparam int EN_BIT = DATA_W - 1;

    typedef struct packed {
        logic             in_frame;
        logic             armed;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] target;
        logic             pending;
        logic             enable;
    } ls_state_t;

    ls_state_t s_d, s_q;
    logic mid_in, mid_arm, hit;

    always_comb begin
        s_d     = s_q;
        hit     = 1'b0;
        mid_in  = s_q.in_frame | (nt_fetch_i & s_q.armed);
        mid_arm = s_q.armed & ~nt_fetch_i;
        s_d.in_frame = mid_in;
        s_d.armed    = mid_arm;

        if (status_rd_i) begin
            s_d.pending = 1'b0;
        end

        if (start_i) begin
            if (!mid_in && !mid_arm) begin
                s_d.armed = 1'b1;
                s_d.count = '0;
            end else begin
                s_d.count = s_q.count + CNT_W'(1);
                hit       = (s_d.count == s_q.target);
                if (hit) begin
                    s_d.pending = 1'b1;
                end
            end
        end

        if (timeout_i) begin
            s_d.in_frame = 1'b0;
        end

        if (vec_rd_i) begin
            s_d.in_frame = 1'b0;
            s_d.count    = '0;
            s_d.pending  = 1'b0;
        end

        if (reg_wr_i) begin
            if (sl_reg_e'(reg_sel_i) == SEL_TARGET) begin
                s_d.target = reg_wdata_i[CNT_W-1:0];
            end else begin
                s_d.enable = reg_wdata_i[EN_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_frame_o = s_q.in_frame;
    assign count_o    = s_q.count;
    assign pending_o  = s_q.pending;
    assign irq_o      = s_q.pending & s_q.enable;

    // R4: a line start inside a frame advances the count by one
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (s_q.in_frame || s_q.armed) && !vec_rd_i)
        |=> (count_o == $past(count_o) + CNT_W'(1)));

    // R5: pending only rises on a line start
    a_r5_pending_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_o) |-> $past(start_i));

    // R7/R8: in-frame only drops on a timeout or a vector fetch
    a_r7_frame_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_frame_o) |-> $past(timeout_i || vec_rd_i));

    // R8: a vector fetch leaves everything cleared
    a_r8_vector_clear: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd_i |=> (!in_frame_o && count_o == '0 && !pending_o && !irq_o));

    // R9: a status read without a new match drops pending
    a_r9_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd_i && !start_i) |=> !pending_o);

endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
    import scanline_pkg::*;
#(
    parameter int VA_W     = 14,
    parameter int TILE_W   = 6,
    parameter int CNT_W    = 8,
    parameter int DATA_W   = 8,
    parameter int IDLE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_rd,
    input  logic [VA_W-1:0]   vid_addr,
    input  logic              cpu_ce,
    input  logic              cpu_rd,
    input  logic [15:0]       cpu_addr,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              status_rd,
    output logic              in_frame,
    output logic [CNT_W-1:0]  line_count,
    output logic              irq_pending,
    output logic              irq,
    output logic [TILE_W-1:0] tile_idx,
    output logic [DATA_W-1:0] status
);
    logic vec_rd, start, nt_fetch, timeout;

    assign vec_rd = cpu_rd && (cpu_addr == VEC_LO_ADDR || cpu_addr == VEC_HI_ADDR);

    sl_fetch_watch #(.VA_W(VA_W), .TILE_W(TILE_W)) u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .vid_rd_i   (vid_rd),
        .vid_addr_i (vid_addr),
        .vec_rd_i   (vec_rd),
        .start_o    (start),
        .nt_fetch_o (nt_fetch),
        .tile_o     (tile_idx)
    );

    sl_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .vid_rd_i  (vid_rd),
        .cpu_ce_i  (cpu_ce),
        .timeout_o (timeout)
    );

    sl_line_state #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .nt_fetch_i  (nt_fetch),
        .timeout_i   (timeout),
        .vec_rd_i    (vec_rd),
        .status_rd_i (status_rd),
        .reg_wr_i    (reg_wr),
        .reg_sel_i   (reg_sel),
        .reg_wdata_i (reg_wdata),
        .in_frame_o  (in_frame),
        .count_o     (line_count),
        .pending_o   (irq_pending),
        .irq_o       (irq)
    );

    always_comb begin
        status = '0;
        status[DATA_W-1] = irq_pending;
        status[DATA_W-2] = in_frame;
    end

    // R5: the request line never rises without a pending flag
    a_r5_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_pending);

endmodule

// File: tb/tb_scanline_irq_unit.sv
module tb_scanline_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        vid_rd;
    logic [13:0] vid_addr;
    logic        cpu_ce;
    logic        cpu_rd;
    logic [15:0] cpu_addr;
    logic        reg_wr;
    logic        reg_sel;
    logic [7:0]  reg_wdata;
    logic        status_rd;
    logic        in_frame;
    logic [7:0]  line_count;
    logic        irq_pending;
    logic        irq;
    logic [5:0]  tile_idx;
    logic [7:0]  status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    scanline_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .vid_rd(vid_rd), .vid_addr(vid_addr),
        .cpu_ce(cpu_ce), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .status_rd(status_rd), .in_frame(in_frame), .line_count(line_count),
        .irq_pending(irq_pending), .irq(irq), .tile_idx(tile_idx), .status(status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    // all stimulus tasks start and end 1 ns after a rising edge
    task automatic vread(input logic [13:0] a);
        vid_rd = 1'b1; vid_addr = a;
        @(posedge clk); #1;
        vid_rd = 1'b0;
    endtask

    task automatic line_end(input logic [13:0] a);
        for (int i = 0; i < 3; i++) vread(a);
    endtask

    task automatic cpu_read(input logic [15:0] a);
        cpu_rd = 1'b1; cpu_addr = a;
        @(posedge clk); #1;
        cpu_rd = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_status();
        status_rd = 1'b1;
        @(posedge clk); #1;
        status_rd = 1'b0;
    endtask

    task automatic ce_pulse();
        cpu_ce = 1'b1;
        @(posedge clk); #1;
        cpu_ce = 1'b0;
    endtask

    task automatic t_reset();
        eq("R1 in_frame", in_frame, 0);
        eq("R1 line_count", line_count, 0);
        eq("R1 irq_pending", irq_pending, 0);
        eq("R1 irq", irq, 0);
        eq("R1 tile_idx", tile_idx, 0);
        eq("R1 status", status, 0);
    endtask

    task automatic t_first_line();
        vread(14'h2005); vread(14'h2005);
        eq("R6 tile after two fetches", tile_idx, 2);
        vread(14'h2005);
        eq("R6 tile reset on line start", tile_idx, 0);
        eq("R3 not yet in frame", in_frame, 0);
        vread(14'h2040);
        eq("R3 in frame after fetch", in_frame, 1);
        eq("R3 count loaded 0", line_count, 0);
        eq("R6 tile after fetch", tile_idx, 1);
    endtask

    task automatic t_repeat_rules();
        vread(14'h2080); vread(14'h0000); vread(14'h2080); vread(14'h2080);
        eq("R2 broken run no start (tile)", tile_idx, 4);
        eq("R2 broken run no start (count)", line_count, 0);
        vread(14'h2080);
        eq("R2 third identical starts", line_count, 1);
        eq("R6 start beats increment", tile_idx, 0);
        vread(14'h2080);
        eq("R2 fourth identical ignored (count)", line_count, 1);
        eq("R2 fourth identical ignored (tile)", tile_idx, 1);
        vread(14'h23C0);
        eq("R6 attribute read keeps tile", tile_idx, 1);
    endtask

    task automatic t_target();
        wr(1'b0, 8'd3); wr(1'b1, 8'h80);
        line_end(14'h2100);
        eq("R4 count 2", line_count, 2);
        eq("R5 no match yet", irq_pending, 0);
        line_end(14'h2140);
        eq("R5 match count", line_count, 3);
        eq("R5 pending on match", irq_pending, 1);
        eq("R5 irq on match", irq, 1);
        eq("R9 status both bits", status, 8'hC0);
        rd_status();
        eq("R9 status read clears pending", irq_pending, 0);
        eq("R9 irq falls", irq, 0);
        eq("R9 status in-frame only", status, 8'h40);
    endtask

    task automatic t_enable();
        wr(1'b1, 8'h00); wr(1'b0, 8'd5);
        line_end(14'h2180); line_end(14'h21C0);
        eq("R10 pending while disabled", irq_pending, 1);
        eq("R10 irq masked", irq, 0);
        wr(1'b1, 8'h80);
        eq("R5 enable with pending raises irq", irq, 1);
        wr(1'b1, 8'h7F);
        eq("R10 only bit7 enables", irq, 0);
        eq("R10 pending kept", irq_pending, 1);
        rd_status();
        wr(1'b1, 8'h80);
    endtask

    task automatic t_idle();
        vread(14'h2000);
        eq("R7 in frame", in_frame, 1);
        ce_pulse(); ce_pulse();
        eq("R7 two clocks still in frame", in_frame, 1);
        ce_pulse();
        eq("R7 third clock drops frame", in_frame, 0);
        eq("R7 status bit6 clear", status, 0);
        line_end(14'h2200);
        eq("R3 rearm loads count 0", line_count, 0);
        eq("R3 rearm not in frame", in_frame, 0);
        vread(14'h2204);
        eq("R3 rearm then in frame", in_frame, 1);
    endtask

    task automatic t_vector();
        wr(1'b0, 8'd1);
        line_end(14'h2240);
        eq("R5 target 1 pending", irq_pending, 1);
        cpu_read(16'hFFFC);
        eq("R8 other address no effect", line_count, 1);
        eq("R8 other address keeps irq", irq, 1);
        cpu_read(16'hFFFB);
        eq("R8 vector clears frame", in_frame, 0);
        eq("R8 vector clears count", line_count, 0);
        eq("R8 vector clears pending", irq_pending, 0);
        eq("R8 vector drops irq", irq, 0);
        vread(14'h2300); vread(14'h2300);
        eq("R6 tile before vector", tile_idx, 2);
        cpu_read(16'hFFFA);
        vread(14'h2300);
        eq("R8 previous address cleared", tile_idx, 3);
    endtask

    task automatic t_wrap();
        wr(1'b0, 8'd0);
        line_end(14'h2380);
        vread(14'h2384);
        eq("R5 arming never matches", irq_pending, 0);
        for (int i = 0; i < 255; i++) line_end((i % 2) ? 14'h2400 : 14'h2404);
        eq("R4 count 255", line_count, 255);
        eq("R4 no pending at 255", irq_pending, 0);
        line_end(14'h2400);
        eq("R4 wrap to 0", line_count, 0);
        eq("R5 match after wrap", irq_pending, 1);
    endtask

    initial begin
        rst_n = 1'b0; vid_rd = 1'b0; vid_addr = '0; cpu_ce = 1'b0;
        cpu_rd = 1'b0; cpu_addr = '0; reg_wr = 1'b0; reg_sel = 1'b0;
        reg_wdata = '0; status_rd = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_first_line();
        t_repeat_rules();
        t_target();
        t_enable();
        t_idle();
        t_vector();
        t_wrap();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule